// File: doc/BRIEF.md
# Gated Pulse-Width Counter

This block measures how long an asynchronous input pulse stays high, in periods of the reference clock. The input is first brought into the clock domain by a short synchronizer chain. A small controller turns the synchronized level into a counting enable that starts only on a clean low-to-high transition and ends on the first low sample. This is the single-domain form of a gate that opens on one clock edge and closes on the opposite edge, so the count never sees a partial clock period. The enable drives a wide saturating counter.

When the pulse ends, the count is copied into a result register and a done flag is raised. A reader collects the width and pulses an acknowledge, which clears the counter and re-arms the block. Until that acknowledge arrives the block holds its result, and any new pulse is ignored and reported through a missed-pulse flag. A pulse that is already high when the block is armed is never measured, because only a rising transition starts a count.

Top module: `pulse_width_meter`

## Requirements
- R1: While reset is high and on the first cycle after it, done, overflow and missed read 0 and width reads 0.
- R2: When the input is sampled high on N consecutive clock edges, with N no larger than 2^COUNT_W-1, width reports N and overflow reads 0.
- R3: If the input is first sampled high on edge k and last sampled high on edge k+N-1, done and width first show the new result after edge k+N+SYNC_STAGES, and done is still 0 after edge k+N+SYNC_STAGES-1.
- R4: While done is 1 and ack is 0, done stays 1 and width does not change.
- R5: An ack seen on a clock edge while done is 1 makes done, overflow and missed read 0 after that edge, and re-arms the block for the next pulse.
- R6: The count saturates at 2^COUNT_W-1 and does not wrap; a pulse sampled high on more than 2^COUNT_W-1 edges reports width 2^COUNT_W-1 with overflow 1.
- R7: A pulse that starts while done is 1 is not measured: width and done are unchanged, missed becomes 1, and that pulse produces no result after the ack.
- R8: An input that is already high when the block leaves reset is not measured; a count starts only on a low-to-high transition of the synchronized input.
- R9: An ack while done is 0 has no effect: done, missed and overflow stay 0 and the next pulse is measured normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; widths are counted in its periods |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous pulse to be measured |
| ack | input | 1 | Reader acknowledge; clears the result and re-arms |
| done | output | 1 | A completed width is available |
| width | output | COUNT_W | Captured pulse width in clock periods |
| overflow | output | 1 | The captured pulse exceeded the counter range |
| missed | output | 1 | A pulse began before the last result was acknowledged |

## Verification
The result of a pulse is due a fixed number of edges after the last high sample: SYNC_STAGES edges through the synchronizer plus one edge for the capture, so with two stages a pulse held over N edges shows done after edge N+3. The driver counts edges from the first sampled-high edge and checks that done is still low one edge before that point and high exactly at it, while a scoreboard monitor compares the width and overflow of each new result against the queued expectation. The effect of ack is due one edge after it is sampled, and the checks read done, overflow and missed at the falling edge right after. Ignored pulses are judged by waiting well beyond the result latency and confirming that no new result appeared.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Controller phases of one measurement
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_COUNT   = 2'd1,
        ST_HOLDING = 2'd2
    } meas_state_e;

    // Commands from the controller to the counter
    typedef struct packed {
        logic clear;
        logic enable;
    } cnt_ctl_t;

    // Extra edges from the last synchronized high sample to the result flag
    localparam int unsigned CAPTURE_LATENCY = 1;

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Stages reset high so that a pulse already in progress at reset
    // does not look like a fresh rising transition.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else     chain[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pwm_gate.sv
module pwm_gate
    import pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level,
    input  logic     ack,
    output cnt_ctl_t ctl,
    output logic     capture,
    output logic     done,
    output logic     missed
);
    meas_state_e state;
    logic        level_q;
    logic        rise;

    assign rise = level & ~level_q;

    always_comb begin
        ctl.enable = ((state == ST_ARMED) && rise) || ((state == ST_COUNT) && level);
        ctl.clear  = (state == ST_HOLDING) && ack;
        capture    = (state == ST_COUNT) && !level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_ARMED;
            level_q <= 1'b1;
            done    <= 1'b0;
            missed  <= 1'b0;
        end else begin
            level_q <= level;
            unique case (state)
                ST_ARMED: if (rise) state <= ST_COUNT;
                ST_COUNT: if (!level) begin
                    state <= ST_HOLDING;
                    done  <= 1'b1;
                end
                ST_HOLDING: begin
                    if (ack) begin
                        state  <= ST_ARMED;
                        done   <= 1'b0;
                        missed <= 1'b0;
                    end else if (rise) begin
                        missed <= 1'b1;
                    end
                end
                default: state <= ST_ARMED;
            endcase
        end
    end

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        done && !ack |=> done); // R4
    AST_ACK_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        done && ack |=> !done && !missed); // R5
    AST_MISSED_WHILE_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(missed) |-> done); // R7
    AST_NO_COUNT_WHILE_HOLDING: assert property (@(posedge clk) disable iff (rst)
        done |-> !ctl.enable); // R7
endmodule

// File: rtl/pwm_sat_counter.sv
module pwm_sat_counter
    import pwm_pkg::*;
#(
    parameter int unsigned WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    output logic [WIDTH-1:0] count,
    output logic             saturated
);
    localparam logic [WIDTH-1:0] MAX_COUNT = {WIDTH{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            count     <= '0;
            saturated <= 1'b0;
        end else if (ctl.enable) begin
            if (count == MAX_COUNT) saturated <= 1'b1;
            else                    count     <= count + 1'b1;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (count == MAX_COUNT) && ctl.enable && !ctl.clear |=> count == MAX_COUNT); // R6
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> count == '0 && !saturated); // R5
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
    import pwm_pkg::*;
#(
    parameter int unsigned COUNT_W     = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pulse_in,
    input  logic               ack,
    output logic               done,
    output logic [COUNT_W-1:0] width,
    output logic               overflow,
    output logic               missed
);
    logic               level;
    cnt_ctl_t           ctl;
    logic               capture;
    logic [COUNT_W-1:0] count;
    logic               saturated;

    pwm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pulse_in),
        .sync_out (level)
    );

    pwm_gate gate_i (
        .clk     (clk),
        .rst     (rst),
        .level   (level),
        .ack     (ack),
        .ctl     (ctl),
        .capture (capture),
        .done    (done),
        .missed  (missed)
    );

    pwm_sat_counter #(.WIDTH(COUNT_W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .count     (count),
        .saturated (saturated)
    );

    // Result register loaded on the first low sample after a pulse
    always_ff @(posedge clk) begin
        if (rst)          width <= '0;
        else if (capture) width <= count;
    end

    assign overflow = saturated;

    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (rst)
        done && !ack |=> $stable(width)); // R4
    AST_OVERFLOW_HELD: assert property (@(posedge clk) disable iff (rst)
        done && !ack |=> $stable(overflow)); // R4
    AST_DONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(capture)); // R3
endmodule

// File: tb/pulse_width_meter_tb_top.sv
`timescale 1ns/1ps
module pulse_width_meter_tb_top;
    localparam int unsigned CW   = 6;
    localparam int unsigned SYNC = 2;
    localparam int unsigned MAXV = (1 << CW) - 1;

    typedef struct {
        int unsigned w;
        bit          ov;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pulse_in = 1'b0;
    logic          ack = 1'b0;
    logic          done;
    logic [CW-1:0] width;
    logic          overflow;
    logic          missed;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    exp_item_t   exp_q[$];
    logic        done_seen = 1'b0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    pulse_width_meter #(.COUNT_W(CW), .SYNC_STAGES(SYNC)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .ack      (ack),
        .done     (done),
        .width    (width),
        .overflow (overflow),
        .missed   (missed)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Monitor: compares each new result against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done && !done_seen) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", int'(width), -1);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    check(int'(width) == e.w, "R2/R6 width", int'(width), int'(e.w));
                    check(overflow == e.ov, "R6 overflow", int'(overflow), int'(e.ov));
                end
            end
            done_seen = done;
        end else begin
            done_seen = 1'b0;
        end
    end

    // Driver: holds the input high over n edges, queues expectation, checks timing (R3)
    task automatic measure(input int unsigned n);
        exp_item_t e;
        e.w  = (n > MAXV) ? MAXV : n;
        e.ov = (n > MAXV);
        exp_q.push_back(e);
        @(negedge clk);
        pulse_in = 1'b1;
        repeat (n) @(negedge clk);
        pulse_in = 1'b0;
        repeat (SYNC) @(negedge clk);
        check(done == 1'b0, "R3 done early", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R3 done on time", int'(done), 1);
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(done == 1'b0, "R5 done cleared", int'(done), 0);
        check(overflow == 1'b0, "R5 overflow cleared", int'(overflow), 0);
        check(missed == 1'b0, "R5 missed cleared", int'(missed), 0);
    endtask

    initial begin
        // R8: input already high across reset release
        pulse_in = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && width == '0, "R1 reset state", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && overflow == 1'b0 && missed == 1'b0, "R1 after reset",
              int'({done, overflow, missed}), 0);
        repeat (8) @(negedge clk);
        pulse_in = 1'b0;
        repeat (10) @(negedge clk);
        check(done == 1'b0, "R8 pre-existing pulse ignored", int'(done), 0);

        // R2/R3/R5: several widths
        measure(1);  do_ack();
        measure(5);  do_ack();
        measure(17); do_ack();

        // R4: result held while unacknowledged
        measure(9);
        repeat (12) @(negedge clk);
        check(done == 1'b1, "R4 done held", int'(done), 1);
        check(int'(width) == 9, "R4 width held", int'(width), 9);
        do_ack();

        // R6: exact top of range and beyond
        measure(MAXV);     do_ack();
        measure(MAXV + 7); do_ack();

        // R9: ack while idle has no effect
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check(done == 1'b0 && missed == 1'b0 && overflow == 1'b0, "R9 idle ack",
              int'({done, overflow, missed}), 0);
        measure(3); do_ack();

        // R7: pulse during holding is ignored and flagged
        measure(4);
        @(negedge clk); pulse_in = 1'b1;
        repeat (6) @(negedge clk); pulse_in = 1'b0;
        repeat (6) @(negedge clk);
        check(int'(width) == 4, "R7 width unchanged", int'(width), 4);
        check(done == 1'b1, "R7 done unchanged", int'(done), 1);
        check(missed == 1'b1, "R7 missed set", int'(missed), 1);
        do_ack();
        repeat (10) @(negedge clk);
        check(done == 1'b0, "R7 no late result", int'(done), 0);

        // R7/R8: pulse rising before ack and still high after it
        measure(2);
        @(negedge clk); pulse_in = 1'b1;
        repeat (4) @(negedge clk);
        do_ack();
        repeat (5) @(negedge clk); pulse_in = 1'b0;
        repeat (10) @(negedge clk);
        check(done == 1'b0, "R7 straddling pulse ignored", int'(done), 0);

        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule